// File: doc/BRIEF.md
# Power-Aware Banked RAM

This block is a 4096-word by 4-bit memory with one write port and one read port. It is built from four physical banks, each 1024 words deep and 4 bits wide. The banks share the low ten address bits. The top two address bits pick one bank, so each access switches only that bank instead of all four.

Each port's enable is folded into a per-bank clock enable. That enable is also ANDed with a user clock enable, which gates the whole memory. Banks that are not selected hold their storage and their output registers. A read takes one cycle. The bank number used at read time is registered, so the output multiplexer follows the bank that actually produced the word.

Top module: `pa_banked_ram`

## Requirements
- R1: Every one of the 4096 addresses stores the 4-bit word written to it, and reading that address returns the word.
- R2: Bank b (0..3) is the bank whose number equals address bits [11:10]. Write-port clock enable bit b is high exactly when wr_en and user_ce are high and wr_addr[11:10] equals b. Read-port clock enable bit b is high exactly when rd_en and user_ce are high and rd_addr[11:10] equals b.
- R3: In any cycle, at most one bit of bank_wr_ce is high, and at most one bit of bank_rd_ce is high.
- R4: While user_ce is low, no write changes the memory, and rd_data does not change even when rd_en is high.
- R5: A read accepted at a clock edge shows its data on rd_data right after that edge. rd_data then holds until the next accepted read, even if rd_addr moves to another bank in the meantime.
- R6: A write and a read to the same address in the same cycle return the word stored before that write. The new word is returned by a later read.
- R7: While rst_n is low at a clock edge, rd_data becomes 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; clears the read path |
| user_ce | input | 1 | User clock enable, ANDed into every bank enable |
| wr_en | input | 1 | Write request |
| wr_addr | input | 12 | Write address; bits [11:10] select the bank |
| wr_data | input | 4 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address; bits [11:10] select the bank |
| rd_data | output | 4 | Read data, one cycle after an accepted read |
| bank_wr_ce | output | 4 | Per-bank write clock enables |
| bank_rd_ce | output | 4 | Per-bank read clock enables |

## Verification
The bench writes every address and reads every address back. This sweep catches a decoder that sends a bank boundary to the wrong bank, or low address bits that alias between banks. It also checks the per-bank enables for each address, so a decoder that raises two enables at once, or raises the wrong one, is reported directly.

Several corner cases get their own checks:
- A read-port mux that uses the live address instead of the registered bank number is caught by moving rd_addr to another bank while rd_en is low; rd_data must not change.
- A design that drops the user enable is caught by attempted writes and reads with user_ce low. The writes would corrupt data that is read back later, and the reads would change rd_data.
- A write-first memory would return the new word on a same-address read and write, and that check would fail.

// File: rtl/pa_banked_ram.sv
module pa_banked_ram #(
  parameter int DATA_W  = 4,
  parameter int BANK_AW = 10,
  parameter int BANKS   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  user_ce,
  input  logic                                  wr_en,
  input  logic [BANK_AW+$clog2(BANKS)-1:0]      wr_addr,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  rd_en,
  input  logic [BANK_AW+$clog2(BANKS)-1:0]      rd_addr,
  output logic [DATA_W-1:0]                     rd_data,
  output logic [BANKS-1:0]                      bank_wr_ce,
  output logic [BANKS-1:0]                      bank_rd_ce
);
  localparam int SEL_W = $clog2(BANKS);
  localparam int AW    = BANK_AW + SEL_W;
  localparam int DEPTH = 1 << BANK_AW;

  logic [SEL_W-1:0]  wr_bank, rd_bank, sel_q;
  logic              wr_go, rd_go;
  logic [DATA_W-1:0] bank_q [BANKS];

  assign wr_bank = wr_addr[AW-1 -: SEL_W];
  assign rd_bank = rd_addr[AW-1 -: SEL_W];
  assign wr_go   = wr_en & user_ce;
  assign rd_go   = rd_en & user_ce;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;

    assign bank_wr_ce[b] = wr_go && (wr_bank == SEL_W'(b));
    assign bank_rd_ce[b] = rd_go && (rd_bank == SEL_W'(b));

    always_ff @(posedge clk)
      if (bank_wr_ce[b]) mem[wr_addr[BANK_AW-1:0]] <= wr_data;

    always_ff @(posedge clk)
      if (!rst_n)             q <= '0;
      else if (bank_rd_ce[b]) q <= mem[rd_addr[BANK_AW-1:0]];

    assign bank_q[b] = q;
  end

  always_ff @(posedge clk)
    if (!rst_n)     sel_q <= '0;
    else if (rd_go) sel_q <= rd_bank;

  assign rd_data = bank_q[sel_q];
endmodule

module pa_banked_ram_chk #(
  parameter int DATA_W = 4,
  parameter int AW     = 12,
  parameter int BANKS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              user_ce,
  input logic              rd_en,
  input logic [AW-1:0]     rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [BANKS-1:0]  bank_wr_ce,
  input logic [BANKS-1:0]  bank_rd_ce
);
  localparam int SEL_W = $clog2(BANKS);

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_wr_ce)); // R3
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_rd_ce)); // R3
  AST_RD_BANK:   assert property (@(posedge clk) disable iff (!rst_n)
                   (bank_rd_ce != '0) |-> bank_rd_ce[rd_addr[AW-1 -: SEL_W]]); // R2
  AST_UCE_GATE:  assert property (@(posedge clk) disable iff (!rst_n)
                   !user_ce |-> (bank_wr_ce == '0 && bank_rd_ce == '0)); // R4
  AST_RD_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                   !(rd_en && user_ce) |=> $stable(rd_data)); // R5
  AST_RST_CLR:   assert property (@(posedge clk) !rst_n |=> rd_data == '0); // R7
endmodule

bind pa_banked_ram pa_banked_ram_chk #(.DATA_W(DATA_W), .AW(AW), .BANKS(BANKS)) i_chk (
  .clk(clk), .rst_n(rst_n), .user_ce(user_ce), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .bank_wr_ce(bank_wr_ce), .bank_rd_ce(bank_rd_ce));

// File: tb/test_pa_banked_ram.sv
module test_pa_banked_ram;
  logic        clk = 0;
  logic        rst_n = 0, user_ce = 0, wr_en = 0, rd_en = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [3:0]  wr_data = 0;
  logic [3:0]  rd_data;
  logic [3:0]  bank_wr_ce, bank_rd_ce;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pa_banked_ram i_pa_banked_ram (
    .clk(clk), .rst_n(rst_n), .user_ce(user_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .bank_wr_ce(bank_wr_ce), .bank_rd_ce(bank_rd_ce));

  function automatic logic [3:0] pat(int a);
    return 4'((a * 7) ^ (a >> 6));
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check("R7", rd_data, 4'h0);
    rst_n = 1; user_ce = 1;
    for (int a = 0; a < 4096; a++) begin
      step();
      wr_en = 1; wr_addr = 12'(a); wr_data = pat(a);
      #1;
      check("R2", bank_wr_ce, 4'(1 << (a >> 10)));
      check("R3", bank_rd_ce, 4'h0);
    end
    step(); wr_en = 0;
    for (int a = 0; a <= 4096; a++) begin
      step();
      if (a > 0) check("R1", rd_data, pat(a - 1));
      if (a < 4096) begin
        rd_en = 1; rd_addr = 12'(a);
        #1;
        check("R2", bank_rd_ce, 4'(1 << (a >> 10)));
      end else rd_en = 0;
    end
    // R5: hold with address moving to other banks while idle
    for (int k = 0; k < 4; k++) begin
      rd_addr = 12'(k * 1024 + 17);
      step();
      check("R5", rd_data, pat(4095));
    end
    // R4: user_ce low gates writes and reads
    user_ce = 0; wr_en = 1; wr_addr = 12'd5; wr_data = ~pat(5);
    #1; check("R4", bank_wr_ce, 4'h0);
    step(); wr_addr = 12'd3000; wr_data = ~pat(3000);
    step(); wr_en = 0; rd_en = 1; rd_addr = 12'd3000;
    #1; check("R4", bank_rd_ce, 4'h0);
    step(); check("R4", rd_data, pat(4095));
    step(); check("R4", rd_data, pat(4095));
    user_ce = 1; rd_addr = 12'd5;
    step(); check("R4", rd_data, pat(5));
    rd_addr = 12'd3000;
    step(); check("R4", rd_data, pat(3000));
    // R5: one-cycle latency across banks
    rd_addr = 12'd1023;
    step(); check("R5", rd_data, pat(1023));
    rd_addr = 12'd1024;
    step(); check("R5", rd_data, pat(1024));
    rd_en = 0; rd_addr = 12'd2048;
    step(); check("R5", rd_data, pat(1024));
    // R6: same-address read during write returns old data
    wr_en = 1; wr_addr = 12'd2500; wr_data = ~pat(2500);
    rd_en = 1; rd_addr = 12'd2500;
    step(); check("R6", rd_data, pat(2500));
    wr_en = 0;
    step(); check("R6", rd_data, ~pat(2500));
    rd_en = 0;
    // R7: reset clears output
    rst_n = 0;
    step(); check("R7", rd_data, 4'h0);
    rst_n = 1;
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule